// File: doc/BRIEF.md
# Leveled Maskable Interrupt Arbiter

This block sits between a set of peripheral event sources and a processor's interrupt input. Each source raises a one-cycle pulse. If the source is enabled, the pulse sets a sticky pending flag, and the flag stays set until software clears it. Every source carries a programmable three-bit priority level. On every clock the arbiter looks at all enabled pending flags and picks one winner. The highest level wins, and among equal levels the lowest source index wins.

The winner is offered to the processor only when the processor's global enable is set and the winner's level is strictly above the processor's current level. A separate non-maskable input overrides all of this. The request line, vector number and level leave the block from registers, one clock after the state and inputs that produced them. A small word-indexed register bus gives access to the level fields, the pending flags and the enables.

Top module: `irq_level_arbiter`

## Requirements
- R1: After a synchronous reset, every pending flag, enable bit and level field is 0, and irq_req, irq_nmi, irq_vec and irq_lvl are 0.
- R2: A pulse on src_pulse[i] sets pending flag i at the next edge only if enable bit i was already 1 before that edge. A pulse on a disabled source leaves the flag at 0.
- R3: A pending flag stays at 1 until a bus write to register index 8 (the flag register) carries a 1 in bit i. Writing 0 to that bit leaves the flag unchanged.
- R4: If a source pulses in the same cycle that its flag is cleared, the flag ends up set.
- R5: Level register k (bus index 0 to 7) holds the level of source 2k in bits 2:0 and the level of source 2k+1 in bits 10:8. All its other bits read as 0.
- R6: Outside the non-maskable case, irq_req is 1 only when cpu_ie was 1 and the winner's level was strictly greater than cpu_il. Otherwise irq_req, irq_vec and irq_lvl are 0.
- R7: Among enabled pending sources, the highest level wins, and a tie goes to the lowest index. The winner's vector is 8 plus its index, and irq_lvl carries its level.
- R8: A source whose enable bit (register index 9, bit i) is 0 does not take part in arbitration, even when its flag is set.
- R9: While nmi_in is 1, the next outputs are irq_req=1, irq_nmi=1, irq_vec=2 and irq_lvl=0, whatever the state of cpu_ie, cpu_il and the flags.
- R10: All request outputs are registered. They reflect the flags, levels and inputs present at the previous clock edge.
- R11: A source that loses arbitration stays pending and wins once the sources ranked above it are cleared.
- R12: bus_rdata is registered and returns the register selected by bus_addr at the previous edge. Indices 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 16 | One-cycle event pulses, one per source |
| nmi_in | input | 1 | Non-maskable request, level sensitive |
| cpu_ie | input | 1 | Processor global maskable enable |
| cpu_il | input | 3 | Processor current interrupt level |
| bus_addr | input | 4 | Register index for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_nmi | output | 1 | Request is the non-maskable one |
| irq_vec | output | 5 | Vector number of the request |
| irq_lvl | output | 3 | Level of the request |

## Verification
The bench targets four corner cases:
- **Strict level compare.** With the winner's level equal to cpu_il, a design that uses greater-or-equal would raise a request here.
- **Equal-level tie.** A design that scans from the top index would report vector 11 instead of 10.
- **Set and clear in the same cycle.** A design that lets the clear win would drop a live event.
- **Enable gating.** A design that gates only on flags would let a disabled pending source win, or would latch a pulse from a disabled source.

Non-maskable overrides with cpu_ie low, level-0 sources that can never request, writes of 0 to the flag register, and masked upper bits in the level registers are also covered. Long random runs then mix all of these against a reference model kept in the bench.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    REG_LEVEL  = 2'd0,
    REG_FLAG   = 2'd1,
    REG_ENABLE = 2'd2,
    REG_NONE   = 2'd3
  } reg_kind_e;

  // Map a register index onto its kind; level registers come first.
  function automatic reg_kind_e decode_kind(input int unsigned idx,
                                            input int unsigned n_lvl_regs);
    if (idx < n_lvl_regs)            return REG_LEVEL;
    else if (idx == n_lvl_regs)      return REG_FLAG;
    else if (idx == n_lvl_regs + 1)  return REG_ENABLE;
    else                             return REG_NONE;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pulse,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] en_q
);

  logic [N-1:0] set_mask;

  assign set_mask = pulse & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | set_mask;
      if (en_wr) en_q <= en_wdata;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask))); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(set_mask)) == $past(set_mask))); // R4

endmodule

// File: rtl/irq_level_bank.sv
module irq_level_bank #(
  parameter int N      = 16,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic [N*LVL_W-1:0] levels
);

  localparam int HALF = DATA_W / 2;

  logic [LVL_W-1:0] lvl_q [N];

  for (genvar i = 0; i < N; i++) begin : g_lvl
    localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(i / 2);
    localparam int                MY_POS = (i % 2) * HALF;

    always_ff @(posedge clk) begin
      if (rst)
        lvl_q[i] <= '0;
      else if (wr_en && wr_idx == MY_IDX)
        lvl_q[i] <= wdata[MY_POS +: LVL_W];
    end

    assign levels[i*LVL_W +: LVL_W] = lvl_q[i];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx == ADDR_W'(i / 2))
        rd_word[(i % 2) * HALF +: LVL_W] = lvl_q[i];
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 16,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       cand,
  input  logic [N*LVL_W-1:0] levels,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl
);

  // Ascending scan with strict compare: ties keep the lower index.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!win_valid || levels[i*LVL_W +: LVL_W] > win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = levels[i*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int N        = 16,
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 5,
  parameter int VEC_BASE = 8,
  parameter int NMI_VEC  = 2,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src_pulse,
  input  logic              nmi_in,
  input  logic              cpu_ie,
  input  logic [LVL_W-1:0]  cpu_il,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic              irq_nmi,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [LVL_W-1:0]  irq_lvl
);
  import irq_arb_pkg::*;

  localparam int IDX_W      = (N > 1) ? $clog2(N) : 1;
  localparam int N_LVL_REGS = (N + 1) / 2;

  reg_kind_e          kind;
  logic [N-1:0]       flags_q, en_q, clr_mask;
  logic [N*LVL_W-1:0] levels;
  logic [DATA_W-1:0]  lvl_word;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;

  assign kind     = decode_kind(32'(bus_addr), N_LVL_REGS);
  assign clr_mask = (bus_wr && kind == REG_FLAG) ? bus_wdata[N-1:0] : '0;

  irq_flag_bank #(.N(N)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .pulse    (src_pulse),
    .clr_mask (clr_mask),
    .en_wr    (bus_wr && kind == REG_ENABLE),
    .en_wdata (bus_wdata[N-1:0]),
    .flags_q  (flags_q),
    .en_q     (en_q)
  );

  irq_level_bank #(.N(N), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_levels (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && kind == REG_LEVEL),
    .wr_idx  (bus_addr),
    .wdata   (bus_wdata),
    .rd_idx  (bus_addr),
    .rd_word (lvl_word),
    .levels  (levels)
  );

  irq_pick #(.N(N), .LVL_W(LVL_W)) u_pick (
    .cand      (flags_q & en_q),
    .levels    (levels),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_nmi <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
    end else if (nmi_in) begin
      irq_req <= 1'b1;
      irq_nmi <= 1'b1;
      irq_vec <= VEC_W'(NMI_VEC);
      irq_lvl <= '0;
    end else if (win_valid && cpu_ie && win_lvl > cpu_il) begin
      irq_req <= 1'b1;
      irq_nmi <= 1'b0;
      irq_vec <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
      irq_lvl <= win_lvl;
    end else begin
      irq_req <= 1'b0;
      irq_nmi <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (kind)
        REG_LEVEL:  bus_rdata <= lvl_word;
        REG_FLAG:   bus_rdata <= DATA_W'(flags_q);
        REG_ENABLE: bus_rdata <= DATA_W'(en_q);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  AST_REQ_ABOVE_IL: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_nmi) |-> ($past(cpu_ie) && irq_lvl > $past(cpu_il))); // R6

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
    nmi_in |=> (irq_req && irq_nmi && irq_vec == VEC_W'(NMI_VEC) && irq_lvl == '0)); // R9

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_nmi) |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec < VEC_W'(VEC_BASE + N))); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (!irq_nmi && irq_vec == '0 && irq_lvl == '0)); // R6

endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_pulse = '0;
  logic        nmi_in = 1'b0;
  logic        cpu_ie = 1'b0;
  logic [2:0]  cpu_il = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_req, irq_nmi;
  logic [4:0]  irq_vec;
  logic [2:0]  irq_lvl;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_flags = '0;
  logic [15:0] m_en    = '0;
  logic [2:0]  m_lvl [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_arbiter u_irq_level_arbiter (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .nmi_in(nmi_in),
    .cpu_ie(cpu_ie), .cpu_il(cpu_il), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_nmi(irq_nmi), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  // Expected outputs {req, nmi, vec, lvl} from the model state before an edge.
  function automatic logic [9:0] exp_out(input logic nmi, input logic ie, input logic [2:0] il);
    logic       found = 1'b0;
    int         best  = 0;
    logic [2:0] bl    = '0;
    if (nmi) return {1'b1, 1'b1, 5'd2, 3'd0};
    for (int i = 0; i < 16; i++)
      if (m_flags[i] && m_en[i] && (!found || m_lvl[i] > bl)) begin
        found = 1'b1; best = i; bl = m_lvl[i];
      end
    if (found && ie && bl > il) return {1'b1, 1'b0, 5'(8 + best), bl};
    return 10'd0;
  endfunction

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    if (a < 4'd8) return {5'd0, m_lvl[2*a+1], 5'd0, m_lvl[2*a]};
    if (a == 4'd8) return m_flags;
    if (a == 4'd9) return m_en;
    return 16'd0;
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] p, input logic nmi, input logic ie, input logic [2:0] il,
                      input logic wr, input logic [3:0] a, input logic [15:0] wd, input string tag);
    logic [9:0]  eo;
    logic [15:0] er, clr;
    src_pulse = p; nmi_in = nmi; cpu_ie = ie; cpu_il = il;
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    eo = exp_out(nmi, ie, il);
    er = exp_read(a);
    @(posedge clk);
    #1;
    clr = (wr && a == 4'd8) ? wd : 16'd0;
    m_flags = (m_flags & ~clr) | (p & m_en);
    if (wr && a == 4'd9) m_en = wd;
    if (wr && a < 4'd8) begin
      m_lvl[2*a]   = wd[2:0];
      m_lvl[2*a+1] = wd[10:8];
    end
    check(tag, "req", 16'(irq_req), 16'(eo[9]));
    check(tag, "nmi", 16'(irq_nmi), 16'(eo[8]));
    check(tag, "vec", 16'(irq_vec), 16'(eo[7:3]));
    check(tag, "lvl", 16'(irq_lvl), 16'(eo[2:0]));
    check(tag, "rdata", bus_rdata, er);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(16'd0, 1'b0, 1'b0, 3'd0, 1'b0, a, 16'd0, tag);
  endtask

  task automatic wrr(input logic [3:0] a, input logic [15:0] d, input string tag);
    step(16'd0, 1'b0, 1'b0, 3'd0, 1'b1, a, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_lvl[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1", "req after reset", 16'(irq_req), 16'd0);
    check("R1", "vec after reset", 16'(irq_vec), 16'd0);
    for (int a = 0; a < 10; a++) rd(4'(a), "R1");
    rd(4'd9, "R12");

    // R5: packing, upper bits masked
    wrr(4'd0, 16'h0503, "R5");
    wrr(4'd1, 16'hFFFF, "R5");
    rd(4'd1, "R5");
    rd(4'd0, "R5");
    rd(4'd12, "R12");

    // R2: pulse on a disabled source is dropped
    step(16'h0001, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R2");
    rd(4'd8, "R2");
    wrr(4'd9, 16'hFFFF, "R8");
    step(16'h0003, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R2");
    rd(4'd8, "R2");
    // R7: src1 level 5 beats src0 level 3
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R7");
    // R6: strict compare, equal level blocked, ie=0 blocked
    step(16'd0, 1'b0, 1'b1, 3'd5, 1'b0, 4'd8, 16'd0, "R6");
    step(16'd0, 1'b0, 1'b1, 3'd5, 1'b0, 4'd8, 16'd0, "R6");
    step(16'd0, 1'b0, 1'b1, 3'd4, 1'b0, 4'd8, 16'd0, "R6");
    step(16'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd8, 16'd0, "R6");
    step(16'd0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd8, 16'd0, "R6");
    // R7 tie: src2 and src3 both level 7
    step(16'h000C, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R7");
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R7");
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R7");
    // R3: writing 0 has no effect
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd8, 16'h0000, "R3");
    rd(4'd8, "R3");
    // R4: set and clear together keeps the flag
    step(16'h0004, 1'b0, 1'b1, 3'd0, 1'b1, 4'd8, 16'h0004, "R4");
    rd(4'd8, "R4");
    // R11: clear src2, src3 then wins
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd8, 16'h0004, "R11");
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R11");
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R11");
    // R8: disable src3, src1 takes over
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd9, 16'hFFF7, "R8");
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R8");
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R8");
    // R9: NMI wins with ie=0 and il=7
    step(16'd0, 1'b1, 1'b0, 3'd7, 1'b0, 4'd8, 16'd0, "R9");
    step(16'd0, 1'b1, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R9");
    // R10: output follows the previous edge only
    step(16'd0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd8, 16'd0, "R10");
    step(16'd0, 1'b0, 1'b1, 3'd7, 1'b0, 4'd8, 16'd0, "R10");
    step(16'd0, 1'b0, 1'b1, 3'd7, 1'b0, 4'd8, 16'd0, "R10");

    for (int k = 0; k < 4000; k++) begin
      logic [15:0] p;
      p = ($urandom % 4 == 0) ? 16'($urandom) : 16'd0;
      step(p, ($urandom % 40) == 0, ($urandom % 4) != 0, 3'($urandom),
           ($urandom % 3) == 0, 4'($urandom % 12), 16'($urandom), "R7");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule